// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block performs one of sixteen 32-bit data-processing operations on two operands and produces the result together with the next values of the four condition flags: negative, zero, carry and overflow. The operations fall into three groups. The logical group covers and, exclusive-or, or, move, bit-clear and move-inverted. The arithmetic group covers add and subtract, both with and without a carry term, and subtraction in both operand orders. The test group covers two logical tests and two arithmetic compares, which set the flags and discard the result.

Operands, opcode, current flags, the carry-out of an upstream shifter and a set-flags request arrive together as one item on a valid/ready input stream. Each accepted item produces exactly one output item one clock later on a valid/ready output stream. The output item carries the result, a write-back enable and the flags. The block holds a single output register. When the consumer keeps `out_ready` low, the block holds that item unchanged and stops accepting input. When the consumer takes the item, a new item may be accepted in the same cycle, so with no back-pressure the block sustains one item per clock.

Top module: `dp_alu`

## Requirements
- R1: The 4-bit opcode selects the operation. 0=and, 1=exclusive-or, 2=subtract (a-b), 3=reverse subtract (b-a), 4=add, 5=add with carry, 6=subtract with carry (a-b-(1-C)), 7=reverse subtract with carry (b-a-(1-C)), 8=test-and, 9=test-exclusive-or, 10=compare (a-b), 11=compare-negated (a+b), 12=or, 13=move (b), 14=bit-clear (a AND NOT b), 15=move-inverted (NOT b).
- R2: The add operations (4, 5, 11) give the 32-bit sum of a and b, plus the incoming C flag for opcode 5.
- R3: The subtract operations give the difference modulo 2^32. Opcodes 2, 6 and 10 compute a minus b. Opcodes 3 and 7 compute b minus a. Opcodes 6 and 7 also subtract 1 when the incoming C flag is 0.
- R4: When flags update, N equals bit 31 of the result and Z is 1 exactly when the result is zero. For test operations, `out_result` still carries the computed value.
- R5: When flags update on an arithmetic operation (2 to 7, 10, 11), C is the carry out of bit 31 for additions. For subtractions C is 1 when no borrow occurs and 0 when a borrow occurs.
- R6: When flags update on an arithmetic operation, V is 1 exactly when the signed two's-complement result overflows 32 bits.
- R7: When flags update on a logical operation (0, 1, 8, 9, 12 to 15), C takes `in_shift_carry` and V keeps its incoming value.
- R8: Opcodes 8 to 11 always update the flags, whatever the state of `in_set_flags`, and drive `out_write` low.
- R9: For opcodes other than 8 to 11, `out_write` is high. If `in_set_flags` is low, `out_flags` equals `in_flags`.
- R10: An item is accepted when `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high on the next clock. `in_ready` is high when the output register is empty or is being taken. While `out_valid` is high and `out_ready` is low, the output item stays stable.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.
- Flag packing on `in_flags` and `out_flags`: bit 3 is N, bit 2 is Z, bit 1 is C, bit 0 is V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item |
| in_opcode | input | 4 | Operation select |
| in_op_a | input | 32 | First operand |
| in_op_b | input | 32 | Second operand |
| in_flags | input | 4 | Current N,Z,C,V |
| in_shift_carry | input | 1 | Shifter carry-out |
| in_set_flags | input | 1 | Request flag update |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the item |
| out_result | output | 32 | Operation result |
| out_write | output | 1 | Result should be written back |
| out_flags | output | 4 | Next N,Z,C,V |

## Verification
Every result, write-back enable and flag set is due exactly one clock after its item is accepted, and it stays due for as long as `out_ready` is held low. The driver sends an item and pushes its expected outcome into a queue only when the handshake completes. The monitor pops one entry per completed output handshake, so stalls move the comparison later without changing what is compared. Outputs are also checked for stability on every stalled cycle.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_test(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // second operand enters the adder inverted
  function automatic logic op_inverts(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // operands swap places before the adder
  function automatic logic op_swaps(alu_op_e op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           carry_flag,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);
  localparam int EW = W + 1;

  logic [W-1:0]  x, y_raw, y;
  logic          cin;
  logic [EW-1:0] wide;

  always_comb begin
    x     = op_swaps(op) ? b : a;
    y_raw = op_swaps(op) ? a : b;
    y     = op_inverts(op) ? ~y_raw : y_raw;
    case (op)
      OP_ADC, OP_SBC, OP_RSC: cin = carry_flag;
      OP_SUB, OP_RSB, OP_CMP: cin = 1'b1;
      default:                cin = 1'b0;
    endcase
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic           set_req,
  input  logic [W-1:0]   res,
  input  logic           add_cout,
  input  logic           add_ovf,
  input  logic           shift_carry,
  input  alu_flags_t     flags_in,
  output alu_flags_t     flags_out,
  output logic           write_en
);
  logic update;

  always_comb begin
    update   = set_req || op_is_test(op);
    write_en = !op_is_test(op);
    flags_out = flags_in;
    if (update) begin
      flags_out.n = res[W-1];
      flags_out.z = (res == '0);
      if (op_is_arith(op)) begin
        flags_out.c = add_cout;
        flags_out.v = add_ovf;
      end else begin
        flags_out.c = shift_carry;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_opcode,
  input  logic [W-1:0]   in_op_a,
  input  logic [W-1:0]   in_op_b,
  input  logic [3:0]     in_flags,
  input  logic           in_shift_carry,
  input  logic           in_set_flags,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_result,
  output logic           out_write,
  output logic [3:0]     out_flags
);
  alu_op_e     op;
  alu_flags_t  fl_in, fl_next;
  logic [W-1:0] logic_res, add_res, res;
  logic        add_cout, add_ovf, wr_next;

  assign op    = alu_op_e'(in_opcode);
  assign fl_in = alu_flags_t'(in_flags);

  dp_alu_logic #(.W(W)) u_logic (
    .op(op), .a(in_op_a), .b(in_op_b), .res(logic_res)
  );

  dp_alu_adder #(.W(W)) u_adder (
    .op(op), .a(in_op_a), .b(in_op_b), .carry_flag(fl_in.c),
    .sum(add_res), .cout(add_cout), .ovf(add_ovf)
  );

  assign res = op_is_arith(op) ? add_res : logic_res;

  dp_alu_flags #(.W(W)) u_flags (
    .op(op), .set_req(in_set_flags), .res(res), .add_cout(add_cout),
    .add_ovf(add_ovf), .shift_carry(in_shift_carry), .flags_in(fl_in),
    .flags_out(fl_next), .write_en(wr_next)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_write  <= 1'b0;
      out_flags  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res;
        out_write  <= wr_next;
        out_flags  <= fl_next;
      end
    end
  end
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_opcode,
  input logic [W-1:0] in_op_a,
  input logic [W-1:0] in_op_b,
  input logic [3:0]   in_flags,
  input logic         in_shift_carry,
  input logic         in_set_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_write,
  input logic [3:0]   out_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_test_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode[3:2] == 2'b10) |=> !out_write);

  p_write_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode[3:2] != 2'b10) |=> out_write);

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_set_flags && in_opcode[3:2] != 2'b10) |=> out_flags == $past(in_flags));

  p_nz_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_set_flags || in_opcode[3:2] == 2'b10)) |=>
      (out_flags[3] == out_result[W-1]) && (out_flags[2] == (out_result == '0)));

  p_logic_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_set_flags && (in_opcode == 4'd0 || in_opcode == 4'd1 || in_opcode == 4'd8 ||
      in_opcode == 4'd9 || in_opcode[3:2] == 2'b11)) |=>
      (out_flags[1] == $past(in_shift_carry)) && (out_flags[0] == $past(in_flags[0])));

  p_accept_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_result) &&
      $stable(out_write) && $stable(out_flags));
endmodule

bind dp_alu dp_alu_checker #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_op_a(in_op_a), .in_op_b(in_op_b),
  .in_flags(in_flags), .in_shift_carry(in_shift_carry),
  .in_set_flags(in_set_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_write(out_write), .out_flags(out_flags)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_opcode = '0;
  logic [W-1:0] in_op_a = '0, in_op_b = '0;
  logic [3:0] in_flags = '0;
  logic in_shift_carry = 1'b0, in_set_flags = 1'b0;
  logic out_valid, out_ready;
  logic [W-1:0] out_result;
  logic out_write;
  logic [3:0] out_flags;

  always #5 clk = ~clk;

  dp_alu #(.W(W)) i_dp_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_op_a(in_op_a), .in_op_b(in_op_b),
    .in_flags(in_flags), .in_shift_carry(in_shift_carry),
    .in_set_flags(in_set_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_write(out_write), .out_flags(out_flags)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         wr;
    logic [3:0]   fl;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int tests = 0, fails = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  initial out_ready = 1'b1;
  always @(negedge clk) out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [3:0] f,
                                 input logic sc, input logic sf, input string tag);
    exp_t e;
    longint sa, sb_, sr;
    logic [W:0] ua, ub, ux;
    logic c_in, arith, test;
    logic [W-1:0] r;
    logic c, v;
    c_in = f[1];
    sa = longint'($signed(a));
    sb_ = longint'($signed(b));
    ua = {1'b0, a};
    ub = {1'b0, b};
    arith = 1'b1;
    c = f[1];
    v = f[0];
    sr = 0;
    r = '0;
    case (op)
      4'd4, 4'd11: begin ux = ua + ub; sr = sa + sb_; end
      4'd5: begin ux = ua + ub + {{W{1'b0}}, c_in}; sr = sa + sb_ + longint'(c_in); end
      4'd2, 4'd10: begin ux = ua - ub; sr = sa - sb_; end
      4'd3: begin ux = ub - ua; sr = sb_ - sa; end
      4'd6: begin ux = ua - ub - {{W{1'b0}}, !c_in}; sr = sa - sb_ - longint'(!c_in); end
      4'd7: begin ux = ub - ua - {{W{1'b0}}, !c_in}; sr = sb_ - sa - longint'(!c_in); end
      default: begin arith = 1'b0; ux = '0; end
    endcase
    if (arith) begin
      r = ux[W-1:0];
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) c = ux[W];
      else c = !ux[W];
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8: r = a & b;
        4'd1, 4'd9: r = a ^ b;
        4'd12: r = a | b;
        4'd13: r = b;
        4'd14: r = a & ~b;
        default: r = ~b;
      endcase
      c = sc;
      v = f[0];
    end
    test = (op >= 4'd8) && (op <= 4'd11);
    e.res = r;
    e.wr = !test;
    e.fl = (sf || test) ? {r[W-1], (r == '0), c, v} : f;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [3:0] f, input logic sc, input logic sf, input string tag);
    in_opcode = op; in_op_a = a; in_op_b = b; in_flags = f;
    in_shift_carry = sc; in_set_flags = sf; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        sb.push_back(model(op, a, b, f, sc, sf, tag));
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per completed output handshake.
  logic [W-1:0] hold_res;
  logic [3:0]   hold_fl;
  bit           was_stalled = 1'b0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (was_stalled)
        check(out_valid && out_result == hold_res && out_flags == hold_fl,
              "R10", "stall hold", out_result, hold_res);
      was_stalled = out_valid && !out_ready;
      hold_res = out_result;
      hold_fl = out_flags;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected output", out_result, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_result == e.res, e.tag, "result", out_result, e.res);
          check(out_write == e.wr, e.tag, "write", {31'b0, out_write}, {31'b0, e.wr});
          check(out_flags == e.fl, e.tag, "flags", {28'b0, out_flags}, {28'b0, e.fl});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R10", "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    check(!out_valid, "R11", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    check(in_ready, "R11", "in_ready in reset", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R11", "out_valid after reset", {31'b0, out_valid}, 32'd0);
    @(negedge clk);

    // R1 logical results, R7 shifter carry and V kept
    send(4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, 1'b1, 1'b1, "R1 and/R7");
    send(4'd1,  32'hAAAA_0000, 32'hAAAA_0000, 4'b0011, 1'b0, 1'b1, "R1 eor zero/R4");
    send(4'd12, 32'h8000_0000, 32'h0000_0001, 4'b0000, 1'b1, 1'b1, "R1 orr/R4 N");
    send(4'd13, 32'h1111_1111, 32'h2222_2222, 4'b1111, 1'b0, 1'b1, "R1 mov/R7");
    send(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0000, 1'b0, 1'b1, "R1 bic");
    send(4'd15, 32'h0,         32'hFFFF_FFFF, 4'b0001, 1'b1, 1'b1, "R1 mvn/R7");
    // R2 add family, R5 carry, R6 overflow
    send(4'd4,  32'h7FFF_FFFF, 32'h1,         4'b0000, 1'b0, 1'b1, "R6 add ovf");
    send(4'd4,  32'hFFFF_FFFF, 32'h1,         4'b0000, 1'b0, 1'b1, "R5 add carry/R4 Z");
    send(4'd5,  32'd10,        32'd20,        4'b0010, 1'b0, 1'b1, "R2 adc C=1");
    send(4'd5,  32'd10,        32'd20,        4'b0000, 1'b0, 1'b1, "R2 adc C=0");
    // R3 subtract family
    send(4'd2,  32'd5,         32'd3,         4'b0000, 1'b0, 1'b1, "R3 sub/R5 no borrow");
    send(4'd2,  32'd3,         32'd5,         4'b0010, 1'b0, 1'b1, "R3 sub/R5 borrow");
    send(4'd2,  32'h8000_0000, 32'h1,         4'b0000, 1'b0, 1'b1, "R6 sub ovf");
    send(4'd3,  32'd3,         32'd5,         4'b0000, 1'b0, 1'b1, "R3 rsb");
    send(4'd6,  32'd5,         32'd3,         4'b0000, 1'b0, 1'b1, "R3 sbc C=0");
    send(4'd6,  32'd5,         32'd3,         4'b0010, 1'b0, 1'b1, "R3 sbc C=1");
    send(4'd7,  32'd3,         32'd5,         4'b0000, 1'b0, 1'b1, "R3 rsc C=0");
    send(4'd6,  32'd0,         32'd0,         4'b0000, 1'b0, 1'b1, "R5 sbc 0-0-1");
    // R8 tests ignore set_flags and never write
    send(4'd10, 32'd42,        32'd42,        4'b0000, 1'b0, 1'b0, "R8 cmp equal");
    send(4'd11, 32'hFFFF_FFFF, 32'h1,         4'b1001, 1'b0, 1'b0, "R8 cmn");
    send(4'd8,  32'hF0,        32'h0F,        4'b0000, 1'b1, 1'b0, "R8 tst");
    send(4'd9,  32'h5,         32'h4,         4'b1101, 1'b0, 1'b0, "R8 teq");
    // R9 set_flags low keeps flags, writes back
    send(4'd4,  32'h7FFF_FFFF, 32'h1,         4'b0110, 1'b0, 1'b0, "R9 add no flags");
    send(4'd0,  32'h0,         32'h0,         4'b1001, 1'b1, 1'b0, "R9 and no flags");
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R10 random traffic under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom);
      send(op, $urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom, 4'($urandom),
           1'($urandom), 1'($urandom), "R10 random");
      if (i % 5 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    stall_en = 1'b0;
    for (int k = 0; k < 50 && sb.size() != 0; k++) @(negedge clk);
    check(sb.size() == 0, "R10", "outstanding items", sb.size(), 32'd0);
    finish_run();
  end
endmodule